// File: doc/BRIEF.md
# Two-Way Latch/Register Bus Transceiver

This block moves an 18-bit word between two ports in both directions. The A-to-B path and the B-to-A path each own one storage element. The same element can work in three ways. It can pass its input straight through (pass mode). It can hold its content. It can capture its input when its capture strobe rises, but only while that path's active-low capture enable is asserted. Each path also has an active-low output enable. That enable only sets a drive-valid flag, which models a released bus. It never changes the data word.

The ports are split for synthesis. Each side has an input vector, an output vector and a drive-valid flag in place of a bidirectional pin. The capture strobes are ordinary signals sampled on the system clock, and their rising edge is found from one stored copy of the previous level. The storage elements use a synchronous active-low reset. The drive-valid flags are combinational and depend on nothing except the output enables, so reset does not affect them.

Top module: `ubt_transceiver`

## Requirements
- R1: While reset is asserted (`rst_n` low at a clock edge), both storage elements clear to zero, so an output shows 0 when its pass input is low.
- R2: While a path's pass input is 1, its output equals its input in the same cycle, with no clock delay.
- R3: After a path's pass input falls, its output keeps the input value that was sampled at the last clock edge while pass was still 1.
- R4: While pass is 0 and the capture strobe has no rising edge, the stored value and the output do not change, whatever the input does.
- R5: While pass is 0 and the capture enable is low (0 = enabled), a 0-to-1 change of the capture strobe between two clock samples loads the input present at that clock edge. The loaded value appears from the next cycle.
- R6: While the capture enable is high, strobe rising edges load nothing.
- R7: A path's drive-valid flag is 1 exactly when its output enable is 0. The output data word is the same whether the flag is 0 or 1.
- R8: The two paths are independent. Activity on one path's controls and data does not change the other path's output or flag.
- R9: A strobe that stays high for several clock cycles loads data only once, at the first rising edge.
- R10: When pass falls in the same cycle as a strobe rising edge (capture enabled), the element loads the input present at that edge, not the value held from pass mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples strobes and updates storage |
| rst_n | input | 1 | Synchronous active-low reset of storage and strobe history |
| a_in | input | 18 | Data entering at side A (source of the A-to-B path) |
| a_out | output | 18 | Data presented at side A by the B-to-A path |
| a_drv | output | 1 | Side A drive-valid flag (0 models high impedance) |
| b_in | input | 18 | Data entering at side B (source of the B-to-A path) |
| b_out | output | 18 | Data presented at side B by the A-to-B path |
| b_drv | output | 1 | Side B drive-valid flag |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ab_pass | input | 1 | A-to-B pass mode select (1 = pass through) |
| ab_strb | input | 1 | A-to-B capture strobe; its rising edge loads data |
| ab_cap_en_n | input | 1 | A-to-B capture enable, active low |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_pass | input | 1 | B-to-A pass mode select |
| ba_strb | input | 1 | B-to-A capture strobe |
| ba_cap_en_n | input | 1 | B-to-A capture enable, active low |

## Verification
A storage element holding the wrong value stays hidden while its path is in pass mode. It shows up on the output in the same cycle that pass goes low. A wrong load caused by a strobe shows up one cycle after the edge that was sampled. The checks therefore read each output in the cycle pass falls and in the cycle after every strobe edge. A lost or extra edge in the strobe history shows up as a load that is missing or repeated while the strobe is held high. The idle path is read throughout, to catch leakage from one direction into the other.

// File: rtl/ubt_pkg.sv
// Package: shared types for the two-way latch/register transceiver.
// Assumes: every lane uses one storage mode per clock cycle.
package ubt_pkg;

    // Next-cycle action of one storage element
    typedef enum logic [1:0] {
        MODE_HOLD    = 2'd0,
        MODE_PASS    = 2'd1,
        MODE_CAPTURE = 2'd2
    } store_mode_e;

    // Number of transfer directions in the block
    localparam int unsigned LANE_CNT = 2;

endpackage

// File: rtl/ubt_edge_det.sv
// Module: finds the rising edge of a strobe sampled on the system clock.
// Assumes: the strobe is synchronous to clk. After reset the history reads
// high, so a strobe already high at reset release does not count as an edge.
module ubt_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic strb,
    output logic strb_prev,
    output logic rise
);

    // Keeps the strobe level from the previous clock sample
    always_ff @(posedge clk) begin
        if (!rst_n) strb_prev <= 1'b1;
        else        strb_prev <= strb;
    end

    // Marks a 0-to-1 change between two samples
    always_comb rise = strb & ~strb_prev;

endmodule

// File: rtl/ubt_mode_dec.sv
// Module: chooses the storage action of one lane for the current cycle.
// Assumes: pass mode has precedence; a capture needs pass low, an edge
// and the active-low enable asserted.
module ubt_mode_dec
    import ubt_pkg::*;
(
    input  logic        pass,
    input  logic        rise,
    input  logic        cap_en_n,
    output store_mode_e mode
);

    // Priority decode of pass, capture and hold
    always_comb begin
        if (pass)                  mode = MODE_PASS;
        else if (rise && !cap_en_n) mode = MODE_CAPTURE;
        else                       mode = MODE_HOLD;
    end

endmodule

// File: rtl/ubt_store.sv
// Module: one storage element with a pass-through mux at its output.
// Assumes: the mode comes from ubt_mode_dec; pass mode reloads each cycle,
// so the element holds the last passed word once pass goes low.
module ubt_store
    import ubt_pkg::*;
#(
    parameter int unsigned W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  store_mode_e  mode,
    input  logic         pass,
    input  logic         rise,
    input  logic         cap_en_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);

    logic [W-1:0] held;
    logic [W-1:0] held_nxt;

    // Picks the next stored word from the decoded mode
    always_comb begin
        unique case (mode)
            MODE_PASS, MODE_CAPTURE: held_nxt = din;
            default:                 held_nxt = held;
        endcase
    end

    // Storage register with synchronous clear
    always_ff @(posedge clk) begin
        if (!rst_n) held <= '0;
        else        held <= held_nxt;
    end

    // Output mux: live input in pass mode, stored word otherwise
    always_comb q = pass ? din : held;

    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> held == '0); // R1
    AST_PASS_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        pass |=> held == $past(din)); // R3
    AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (!pass && !rise) |=> held == $past(held)); // R4
    AST_EDGE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (!pass && rise && !cap_en_n) |=> held == $past(din)); // R5
    AST_GATED_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!pass && cap_en_n) |=> held == $past(held)); // R6

endmodule

// File: rtl/ubt_lane.sv
// Module: one transfer direction: strobe edge finder, mode decode,
// storage element and drive-valid flag.
// Assumes: the output enable is active low and changes only the flag.
module ubt_lane
    import ubt_pkg::*;
#(
    parameter int unsigned W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    input  logic         oe_n,
    input  logic         pass,
    input  logic         strb,
    input  logic         cap_en_n,
    output logic [W-1:0] dout,
    output logic         drv
);

    logic        rise;
    logic        strb_prev;
    store_mode_e mode;

    ubt_edge_det u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .strb      (strb),
        .strb_prev (strb_prev),
        .rise      (rise)
    );

    ubt_mode_dec u_dec (
        .pass     (pass),
        .rise     (rise),
        .cap_en_n (cap_en_n),
        .mode     (mode)
    );

    ubt_store #(.W(W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .pass     (pass),
        .rise     (rise),
        .cap_en_n (cap_en_n),
        .din      (din),
        .q        (dout)
    );

    // Drive-valid flag: the bus is driven only while the enable is low
    always_comb drv = ~oe_n;

    AST_ONE_LOAD_PER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (strb && strb_prev) |-> !rise); // R9

endmodule

// File: rtl/ubt_transceiver.sv
// Module: top level of the 18-bit two-way latch/register transceiver.
// Lane 0 carries A to B, lane 1 carries B to A.
// Assumes: split input/output vectors in place of bidirectional pins.
module ubt_transceiver
    import ubt_pkg::*;
#(
    parameter int unsigned W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic         a_drv,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic         b_drv,
    input  logic         ab_oe_n,
    input  logic         ab_pass,
    input  logic         ab_strb,
    input  logic         ab_cap_en_n,
    input  logic         ba_oe_n,
    input  logic         ba_pass,
    input  logic         ba_strb,
    input  logic         ba_cap_en_n
);

    logic [W-1:0] lane_din  [LANE_CNT];
    logic [W-1:0] lane_dout [LANE_CNT];
    logic         lane_oe_n [LANE_CNT];
    logic         lane_pass [LANE_CNT];
    logic         lane_strb [LANE_CNT];
    logic         lane_cen_n[LANE_CNT];
    logic         lane_drv  [LANE_CNT];

    // Gathers the per-direction controls into lane arrays
    always_comb begin
        lane_din[0]   = a_in;        lane_din[1]   = b_in;
        lane_oe_n[0]  = ab_oe_n;     lane_oe_n[1]  = ba_oe_n;
        lane_pass[0]  = ab_pass;     lane_pass[1]  = ba_pass;
        lane_strb[0]  = ab_strb;     lane_strb[1]  = ba_strb;
        lane_cen_n[0] = ab_cap_en_n; lane_cen_n[1] = ba_cap_en_n;
    end

    for (genvar g = 0; g < LANE_CNT; g++) begin : g_lane
        ubt_lane #(.W(W)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .din      (lane_din[g]),
            .oe_n     (lane_oe_n[g]),
            .pass     (lane_pass[g]),
            .strb     (lane_strb[g]),
            .cap_en_n (lane_cen_n[g]),
            .dout     (lane_dout[g]),
            .drv      (lane_drv[g])
        );
    end

    // Routes lane results to the opposite side of the block
    always_comb begin
        b_out = lane_dout[0];
        b_drv = lane_drv[0];
        a_out = lane_dout[1];
        a_drv = lane_drv[1];
    end

    AST_B_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!ba_pass && ba_cap_en_n) |=> (ba_pass || a_out == $past(a_out))); // R8

endmodule

// File: tb/ubt_transceiver_test.sv
// Bench: a vector table walked once per direction, then directed checks
// of reset clearing and drive-flag independence.
module ubt_transceiver_test;

    localparam int W = 18;
    localparam int ROWS = 14;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] a_out, b_out;
    logic         a_drv, b_drv;
    logic ab_oe_n = 1'b1, ab_pass = 1'b0, ab_strb = 1'b0, ab_cap_en_n = 1'b1;
    logic ba_oe_n = 1'b1, ba_pass = 1'b0, ba_strb = 1'b0, ba_cap_en_n = 1'b1;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    ubt_transceiver #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n),
        .a_in(a_in), .a_out(a_out), .a_drv(a_drv),
        .b_in(b_in), .b_out(b_out), .b_drv(b_drv),
        .ab_oe_n(ab_oe_n), .ab_pass(ab_pass), .ab_strb(ab_strb), .ab_cap_en_n(ab_cap_en_n),
        .ba_oe_n(ba_oe_n), .ba_pass(ba_pass), .ba_strb(ba_strb), .ba_cap_en_n(ba_cap_en_n)
    );

    // Row: pass, strobe, cap_en_n, oe_n, data, expected out, expected flag
    localparam logic [40:0] TBL [ROWS] = '{
        {1'b0,1'b0,1'b1,1'b1,18'h11111,18'h00000,1'b0}, // R1 cleared, R7 flag off
        {1'b1,1'b0,1'b1,1'b0,18'h12345,18'h12345,1'b1}, // R2
        {1'b1,1'b0,1'b1,1'b0,18'h3ABCD,18'h3ABCD,1'b1}, // R2
        {1'b0,1'b0,1'b1,1'b0,18'h00F0F,18'h3ABCD,1'b1}, // R3
        {1'b0,1'b1,1'b1,1'b0,18'h2FFFF,18'h3ABCD,1'b1}, // R6 edge gated
        {1'b0,1'b0,1'b0,1'b0,18'h15555,18'h3ABCD,1'b1}, // R6 nothing loaded
        {1'b0,1'b1,1'b0,1'b0,18'h2AAAA,18'h3ABCD,1'b1}, // R4 before load
        {1'b0,1'b1,1'b0,1'b1,18'h01234,18'h2AAAA,1'b0}, // R5 loaded, R7
        {1'b0,1'b1,1'b0,1'b0,18'h04321,18'h2AAAA,1'b1}, // R9 held high
        {1'b0,1'b0,1'b0,1'b0,18'h3FFFF,18'h2AAAA,1'b1}, // R4
        {1'b1,1'b0,1'b0,1'b0,18'h0F0F0,18'h0F0F0,1'b1}, // R2
        {1'b1,1'b0,1'b0,1'b0,18'h1E1E1,18'h1E1E1,1'b1}, // R2
        {1'b0,1'b1,1'b0,1'b0,18'h2D2D2,18'h1E1E1,1'b1}, // R10 pass falls with edge
        {1'b0,1'b0,1'b0,1'b0,18'h00001,18'h2D2D2,1'b1}  // R10 edge word kept
    };

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=0", 1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int dir = 0; dir < 2; dir++) begin
            do_reset();
            for (int r = 0; r < ROWS; r++) begin
                logic [40:0] row;
                row = TBL[r];
                if (dir == 0) begin
                    {ab_pass, ab_strb, ab_cap_en_n, ab_oe_n, a_in} = row[40:19];
                end else begin
                    {ba_pass, ba_strb, ba_cap_en_n, ba_oe_n, b_in} = row[40:19];
                end
                #1;
                if (dir == 0) begin
                    chk($sformatf("R2-table row %0d b_out", r), b_out, row[18:1]);
                    chk($sformatf("R7 row %0d b_drv", r), {17'd0, b_drv}, {17'd0, row[0]});
                    chk("R8 idle a_out", a_out, '0);
                end else begin
                    chk($sformatf("R2-table row %0d a_out", r), a_out, row[18:1]);
                    chk($sformatf("R7 row %0d a_drv", r), {17'd0, a_drv}, {17'd0, row[0]});
                    chk("R8 idle b_out", b_out, '0);
                end
                @(posedge clk);
                #1;
            end
            ab_pass = 1'b0; ab_strb = 1'b0; ab_cap_en_n = 1'b1; ab_oe_n = 1'b1;
            ba_pass = 1'b0; ba_strb = 1'b0; ba_cap_en_n = 1'b1; ba_oe_n = 1'b1;
        end

        // R1: reset clears a loaded word; R7: flag follows enable during reset
        chk("R1 a_out before reset", a_out, 18'h2D2D2);
        ba_oe_n = 1'b0;
        rst_n = 1'b0;
        @(posedge clk); #1;
        chk("R1 a_out cleared", a_out, '0);
        chk("R7 a_drv in reset", {17'd0, a_drv}, 18'd1);
        chk("R7 b_drv in reset", {17'd0, b_drv}, 18'd0);
        #1 rst_n = 1'b1;

        // R6/R4: pass low, enable high, many strobe toggles load nothing
        for (int k = 0; k < 4; k++) begin
            a_in = 18'h3C3C3 ^ 18'(k);
            ab_strb = ~ab_strb;
            @(posedge clk); #1;
        end
        chk("R6 b_out after gated toggles", b_out, '0);

        // R5: enabled edge loads, then R8 other side unchanged
        ab_cap_en_n = 1'b0; ab_strb = 1'b0;
        @(posedge clk); #1;
        a_in = 18'h24680; ab_strb = 1'b1;
        @(posedge clk); #1;
        a_in = 18'h13579;
        chk("R5 b_out loaded", b_out, 18'h24680);
        chk("R8 a_out unchanged", a_out, '0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule